// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block sits behind a translation cache and resolves a miss by reading the in-memory page table. It receives a 36-bit virtual page number, the kind of access (load or store, user or supervisor) and the physical page number of the root table. It then reads one 8-byte entry per level over a valid/ready memory port, four levels deep. The entry address at each level is the current table base plus the 9-bit index for that level, scaled by eight. At each level the present bit of the returned entry is checked. A non-final entry supplies the page number of the next table.

The final entry is checked against the access rights. If it passes, its physical page number and rights are returned as a fill for the translation cache. Otherwise the walk ends in a fault that reports a two-bit cause and the level at which it stopped. Only one walk runs at a time, and the result is held until the requester acknowledges it.

Top module: `page_walker`

## Requirements
- R1: The entry address at level L equals `{table_ppn, 12'h000} + 8 * idx`, where idx is VPN[35:27] at level 0, VPN[26:18] at level 1, VPN[17:9] at level 2 and VPN[8:0] at level 3. The level-0 table_ppn is `root_ppn`.
- R2: A walk issues its requests in level order, at most four and exactly one per level reached. The table_ppn for level L+1 is bits [51:12] of the entry returned at level L.
- R3: Once `mem_req_valid` is high, it stays high with `mem_req_addr` unchanged until the cycle in which `mem_req_ready` is high.
- R4: `walk_ready` is high only while no walk is in progress and no result is pending. A `walk_valid` presented at any other time starts nothing and leaves the pending result unchanged.
- R5: An entry with bit 0 (present) clear, at any level, ends the walk at once. The result has `res_fault`=1, cause 2'b01 and `res_level` equal to that level, and no further memory request is issued.
- R6: For a user access (`walk_user`=1) whose final entry has bit 2 (user) clear, the result has fault cause 2'b11. This cause wins over a write-protect violation in the same entry.
- R7: For a write access (`walk_write`=1) whose final entry has bit 1 (writable) clear and no R6 violation, the result has fault cause 2'b10.
- R8: A walk with no fault returns `res_fault`=0, cause 2'b00, `res_level`=3, and `res_ppn` equal to bits [51:12] of the final entry. `res_writable` and `res_user` equal bits 1 and 2 of that entry.
- R9: `res_valid` and all result fields stay constant until the cycle in which `res_ack` is high. In the cycle after that, `res_valid` is low and `walk_ready` is high.
- R10: The writable and user bits of non-final entries have no effect on the outcome.
- R11: After reset, `walk_ready`=1, `mem_req_valid`=0 and `res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_valid | input | 1 | Start a walk |
| walk_ready | output | 1 | Walker idle, walk accepted |
| walk_vpn | input | 36 | Virtual page number that missed |
| walk_write | input | 1 | Access is a store |
| walk_user | input | 1 | Access is from user mode |
| root_ppn | input | 40 | Physical page number of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Returned entry |
| res_valid | output | 1 | Walk result available |
| res_ack | input | 1 | Requester consumes the result |
| res_fault | output | 1 | Walk ended in a fault |
| res_cause | output | 2 | 00 none, 01 not present, 10 write-protect, 11 kernel-only |
| res_level | output | 2 | Level at which the walk ended |
| res_ppn | output | 40 | Physical page number for the fill |
| res_writable | output | 1 | Fill: page writable |
| res_user | output | 1 | Fill: page user-accessible |

## Verification
Two checks can fail together in one final entry: a user store to a page that is both supervisor-only and read-only violates both rights at once. The bench builds such entries in directed cases and in random walks with independently drawn flag bits. It expects the kernel-only cause every time. A second overlap is a new `walk_valid` that arrives while a result is still waiting for acknowledgement. The bench asserts it during the hold window and checks that no memory request appears and that the held result does not move.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int LEVELS     = 4;
    localparam int IDX_W      = 9;
    localparam int VPN_W      = LEVELS * IDX_W;
    localparam int PAGE_SHIFT = 12;
    localparam int PTE_BYTES  = 8;
    localparam int PTE_W      = PTE_BYTES * 8;
    localparam int PPN_W      = 40;
    localparam int PA_W       = PPN_W + PAGE_SHIFT;
    localparam int LVL_W      = $clog2(LEVELS);
    localparam int IDX_SHIFT  = $clog2(PTE_BYTES);

    // entry bit positions
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int PPN_LSB     = PAGE_SHIFT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_CHECK,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_ABSENT = 2'b01,
        CAUSE_WRPROT = 2'b10,
        CAUSE_KERNEL = 2'b11
    } fault_cause_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             user;
        logic             writable;
        logic             present;
    } pte_fields_t;

    function automatic pte_fields_t split_pte(input logic [PTE_W-1:0] raw);
        pte_fields_t f;
        f.ppn      = raw[PPN_LSB +: PPN_W];
        f.user     = raw[BIT_USER];
        f.writable = raw[BIT_WRITE];
        f.present  = raw[BIT_PRESENT];
        return f;
    endfunction

    function automatic logic [IDX_W-1:0] vpn_slice(input logic [VPN_W-1:0] vpn,
                                                   input logic [LVL_W-1:0] lvl);
        logic [IDX_W-1:0] s;
        s = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i))
                s = vpn[(LEVELS-1-i)*IDX_W +: IDX_W];
        end
        return s;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PPN_W-1:0] table_ppn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  entry_addr
);
    logic [IDX_W-1:0] idx;
    logic [PA_W-1:0]  table_base;
    logic [PA_W-1:0]  offset;

    always_comb begin
        idx        = vpn_slice(vpn, level);
        table_base = {table_ppn, {PAGE_SHIFT{1'b0}}};
        offset     = PA_W'({idx, {IDX_SHIFT{1'b0}}});
        entry_addr = table_base + offset;
    end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] raw_pte,
    input  logic             is_last,
    input  logic             acc_write,
    input  logic             acc_user,
    output logic             fault,
    output fault_cause_e     cause,
    output pte_fields_t      fields
);
    always_comb begin
        fields = split_pte(raw_pte);
        fault  = 1'b0;
        cause  = CAUSE_NONE;
        if (!fields.present) begin
            fault = 1'b1;
            cause = CAUSE_ABSENT;
        end else if (is_last && acc_user && !fields.user) begin
            fault = 1'b1;
            cause = CAUSE_KERNEL;
        end else if (is_last && acc_write && !fields.writable) begin
            fault = 1'b1;
            cause = CAUSE_WRPROT;
        end
    end
endmodule

// File: rtl/page_walker.sv
module page_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              walk_valid,
    output logic              walk_ready,
    input  logic [VPN_W-1:0]  walk_vpn,
    input  logic              walk_write,
    input  logic              walk_user,
    input  logic [PPN_W-1:0]  root_ppn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ack,
    output logic              res_fault,
    output logic [1:0]        res_cause,
    output logic [LVL_W-1:0]  res_level,
    output logic [PPN_W-1:0]  res_ppn,
    output logic              res_writable,
    output logic              res_user
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e        state;
    logic [VPN_W-1:0]   vpn_q;
    logic [PPN_W-1:0]   base_q;
    logic [LVL_W-1:0]   level_q;
    logic               wr_q;
    logic               usr_q;
    logic [PTE_W-1:0]   pte_q;

    logic               fault_q;
    fault_cause_e       cause_q;
    logic [LVL_W-1:0]   lvl_out_q;
    logic [PPN_W-1:0]   ppn_q;
    logic               wflag_q;
    logic               uflag_q;

    logic               is_last;
    logic               chk_fault;
    fault_cause_e       chk_cause;
    pte_fields_t        chk_fields;

    assign is_last = (level_q == LAST_LVL);

    ptw_addr_gen u_addr (
        .table_ppn  (base_q),
        .vpn        (vpn_q),
        .level      (level_q),
        .entry_addr (mem_req_addr)
    );

    ptw_pte_check u_check (
        .raw_pte   (pte_q),
        .is_last   (is_last),
        .acc_write (wr_q),
        .acc_user  (usr_q),
        .fault     (chk_fault),
        .cause     (chk_cause),
        .fields    (chk_fields)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            vpn_q     <= '0;
            base_q    <= '0;
            level_q   <= '0;
            wr_q      <= 1'b0;
            usr_q     <= 1'b0;
            pte_q     <= '0;
            fault_q   <= 1'b0;
            cause_q   <= CAUSE_NONE;
            lvl_out_q <= '0;
            ppn_q     <= '0;
            wflag_q   <= 1'b0;
            uflag_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (walk_valid) begin
                        vpn_q   <= walk_vpn;
                        base_q  <= root_ppn;
                        wr_q    <= walk_write;
                        usr_q   <= walk_user;
                        level_q <= '0;
                        state   <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready)
                        state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        pte_q <= mem_rsp_data;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (chk_fault) begin
                        fault_q   <= 1'b1;
                        cause_q   <= chk_cause;
                        lvl_out_q <= level_q;
                        ppn_q     <= '0;
                        wflag_q   <= 1'b0;
                        uflag_q   <= 1'b0;
                        state     <= ST_FAULT;
                    end else if (is_last) begin
                        fault_q   <= 1'b0;
                        cause_q   <= CAUSE_NONE;
                        lvl_out_q <= level_q;
                        ppn_q     <= chk_fields.ppn;
                        wflag_q   <= chk_fields.writable;
                        uflag_q   <= chk_fields.user;
                        state     <= ST_DONE;
                    end else begin
                        base_q  <= chk_fields.ppn;
                        level_q <= level_q + 1'b1;
                        state   <= ST_REQ;
                    end
                end
                ST_DONE, ST_FAULT: begin
                    if (res_ack)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign walk_ready    = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_REQ);
    assign res_valid     = (state == ST_DONE) || (state == ST_FAULT);
    assign res_fault     = fault_q;
    assign res_cause     = cause_q;
    assign res_level     = lvl_out_q;
    assign res_ppn       = ppn_q;
    assign res_writable  = wflag_q;
    assign res_user      = uflag_q;
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              walk_valid,
    input logic              walk_ready,
    input logic [VPN_W-1:0]  walk_vpn,
    input logic              walk_write,
    input logic              walk_user,
    input logic [PPN_W-1:0]  root_ppn,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [PTE_W-1:0]  mem_rsp_data,
    input logic              res_valid,
    input logic              res_ack,
    input logic              res_fault,
    input logic [1:0]        res_cause,
    input logic [LVL_W-1:0]  res_level,
    input logic [PPN_W-1:0]  res_ppn,
    input logic              res_writable,
    input logic              res_user
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ack) |=> (res_valid && $stable(res_fault) && $stable(res_cause)
                                     && $stable(res_level) && $stable(res_ppn)
                                     && $stable(res_writable) && $stable(res_user)));

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ack) |=> (walk_ready && !res_valid));

    // R4
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({walk_ready, mem_req_valid, res_valid}));

    // R8
    success_level_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_fault) |-> (res_level == LVL_W'(LEVELS - 1) && res_cause == 2'b00));

    // R6
    perm_level_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault && res_cause != 2'b01) |-> (res_level == LVL_W'(LEVELS - 1)));

    // R5
    fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault) |-> (res_cause != 2'b00));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (walk_ready && !mem_req_valid && !res_valid));
endmodule

bind page_walker page_walker_chk u_chk (.*);

// File: tb/sim_page_walker.sv
module sim_page_walker;
    import ptw_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              walk_valid = 1'b0;
    logic              walk_ready;
    logic [VPN_W-1:0]  walk_vpn = '0;
    logic              walk_write = 1'b0;
    logic              walk_user = 1'b0;
    logic [PPN_W-1:0]  root_ppn = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [PA_W-1:0]   mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [PTE_W-1:0]  mem_rsp_data = '0;
    logic              res_valid;
    logic              res_ack = 1'b0;
    logic              res_fault;
    logic [1:0]        res_cause;
    logic [LVL_W-1:0]  res_level;
    logic [PPN_W-1:0]  res_ppn;
    logic              res_writable;
    logic              res_user;

    always #5 clk = ~clk;

    page_walker u0 (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [PTE_W-1:0] cfg_pte [LEVELS];
    logic [PA_W-1:0]  exp_addr [LEVELS];
    int               exp_n;
    int               req_idx;
    bit               rsp_pending;
    int               rsp_delay;
    logic [PTE_W-1:0] rsp_word;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PTE_W-1:0] mk_pte(input logic [PPN_W-1:0] ppn, input bit p, input bit w, input bit u);
        return {{(PTE_W-PPN_W-PAGE_SHIFT){1'b0}}, ppn, 9'b0, u, w, p};
    endfunction

    function automatic logic [PPN_W-1:0] rnd_ppn();
        return {8'($urandom), 32'($urandom)};
    endfunction

    // memory model: ready stalls at random, responses after random delay
    initial begin
        rsp_pending = 1'b0;
        rsp_delay = 0;
        rsp_word = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rsp_pending) begin
                if (rsp_delay == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rsp_word;
                    rsp_pending   = 1'b0;
                end else begin
                    rsp_delay--;
                end
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (!rst && mem_req_valid && mem_req_ready) begin
                if (req_idx >= exp_n) begin
                    chk(1'b0, "R5 extra request", 64'(req_idx), 64'(exp_n));
                    rsp_word = '0;
                end else begin
                    // R1 R2
                    chk(mem_req_addr == exp_addr[req_idx], "R1 entry address",
                        64'(mem_req_addr), 64'(exp_addr[req_idx]));
                    rsp_word = cfg_pte[req_idx];
                end
                req_idx++;
                rsp_pending = 1'b1;
                rsp_delay = $urandom % 3;
            end
        end
    end

    task automatic run_walk(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] root,
                            input bit wr, input bit usr, input string tag);
        logic [PPN_W-1:0] base;
        bit e_fault;
        logic [1:0] e_cause;
        int e_lvl;
        logic [PPN_W-1:0] e_ppn;
        bit e_w, e_u;
        int wait_n;
        int hold;
        logic [PPN_W-1:0] held_ppn;
        logic [1:0] held_cause;
        int held_idx;

        base = root; e_fault = 0; e_cause = 2'b00; e_lvl = 0; e_ppn = '0; e_w = 0; e_u = 0;
        exp_n = 0;
        for (int l = 0; l < LEVELS; l++) begin
            logic [IDX_W-1:0] idx;
            idx = vpn[(LEVELS-1-l)*IDX_W +: IDX_W];
            exp_addr[l] = {base, 12'h000} + PA_W'(idx) * PA_W'(8);
            exp_n = l + 1;
            e_lvl = l;
            if (!cfg_pte[l][0]) begin
                e_fault = 1; e_cause = 2'b01;
                break;
            end
            if (l == LEVELS - 1) begin
                if (usr && !cfg_pte[l][2]) begin
                    e_fault = 1; e_cause = 2'b11;
                end else if (wr && !cfg_pte[l][1]) begin
                    e_fault = 1; e_cause = 2'b10;
                end else begin
                    e_ppn = cfg_pte[l][51:12]; e_w = cfg_pte[l][1]; e_u = cfg_pte[l][2];
                end
            end
            base = cfg_pte[l][51:12];
        end
        req_idx = 0;

        @(negedge clk);
        chk(walk_ready == 1'b1, "R4 ready when idle", 64'(walk_ready), 64'd1);
        walk_vpn = vpn; root_ppn = root; walk_write = wr; walk_user = usr; walk_valid = 1'b1;
        @(negedge clk);
        walk_valid = 1'b0;
        wait_n = 0;
        while (!res_valid && wait_n < 200) begin
            @(negedge clk);
            wait_n++;
        end
        chk(res_valid == 1'b1, {"R9 result arrives ", tag}, 64'(res_valid), 64'd1);
        chk(req_idx == exp_n, {"R2 request count ", tag}, 64'(req_idx), 64'(exp_n));
        chk(res_fault == e_fault, {"R8 fault flag ", tag}, 64'(res_fault), 64'(e_fault));
        if (e_fault) begin
            // R5 R6 R7
            chk(res_cause == e_cause, {"R6 R7 R5 cause ", tag}, 64'(res_cause), 64'(e_cause));
            chk(int'(res_level) == e_lvl, {"R5 level ", tag}, 64'(res_level), 64'(e_lvl));
        end else begin
            chk(res_cause == 2'b00 && int'(res_level) == 3, {"R8 level ", tag},
                64'(res_level), 64'd3);
            chk(res_ppn == e_ppn && res_writable == e_w && res_user == e_u,
                {"R8 fill ", tag}, 64'({res_ppn, res_writable, res_user}),
                64'({e_ppn, e_w, e_u}));
        end

        // R4: a new request during the hold window must not start anything
        held_ppn = res_ppn; held_cause = res_cause; held_idx = req_idx;
        walk_vpn = ~vpn; walk_valid = 1'b1;
        hold = 1 + ($urandom % 3);
        repeat (hold) @(negedge clk);
        chk(res_valid && res_ppn == held_ppn && res_cause == held_cause && req_idx == held_idx,
            {"R4 R9 busy hold ", tag}, 64'(req_idx), 64'(held_idx));
        walk_valid = 1'b0;
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk(!res_valid && walk_ready, {"R9 release ", tag}, 64'({res_valid, walk_ready}), 64'b01);
    endtask

    task automatic fill_ok(input bit w_last, input bit u_last);
        for (int l = 0; l < LEVELS; l++)
            cfg_pte[l] = mk_pte(rnd_ppn(), 1'b1, 1'b1, 1'b1);
        cfg_pte[LEVELS-1] = mk_pte(rnd_ppn(), 1'b1, w_last, u_last);
    endtask

    initial begin
        void'($urandom(32'd4711));
        exp_n = 0; req_idx = 0;
        for (int l = 0; l < LEVELS; l++) begin
            cfg_pte[l] = '0;
            exp_addr[l] = '0;
        end
        repeat (3) @(negedge clk);
        // R11
        chk(walk_ready && !mem_req_valid && !res_valid, "R11 reset state",
            64'({walk_ready, mem_req_valid, res_valid}), 64'b100);
        rst = 1'b0;

        // R8 plain success; R1 index edges
        fill_ok(1'b1, 1'b1);
        run_walk('0, rnd_ppn(), 1'b1, 1'b1, "zero vpn");
        fill_ok(1'b1, 1'b1);
        run_walk('1, '1, 1'b0, 1'b1, "ones vpn");
        // R7 store to read-only page
        fill_ok(1'b0, 1'b1);
        run_walk(36'h123456789, rnd_ppn(), 1'b1, 1'b1, "R7 write protect");
        // R7 load from read-only page is fine
        fill_ok(1'b0, 1'b1);
        run_walk(36'h0abcdef01, rnd_ppn(), 1'b0, 1'b1, "R7 load ok");
        // R6 user access to supervisor page
        fill_ok(1'b1, 1'b0);
        run_walk(36'h5a5a5a5a5, rnd_ppn(), 1'b0, 1'b1, "R6 kernel only");
        // R6 priority over write protect
        fill_ok(1'b0, 1'b0);
        run_walk(36'h3c3c3c3c3, rnd_ppn(), 1'b1, 1'b1, "R6 priority");
        // supervisor access to supervisor read-only page, store
        fill_ok(1'b0, 1'b0);
        run_walk(36'h0f0f0f0f0, rnd_ppn(), 1'b1, 1'b0, "R7 supervisor store");
        // R5 absent at each level
        for (int l = 0; l < LEVELS; l++) begin
            fill_ok(1'b1, 1'b1);
            cfg_pte[l] = mk_pte(rnd_ppn(), 1'b0, 1'b1, 1'b1);
            run_walk({4'($urandom), 32'($urandom)}, rnd_ppn(), 1'b1, 1'b1, "R5 absent");
        end
        // R10 rights on non-final entries ignored
        fill_ok(1'b1, 1'b1);
        for (int l = 0; l < LEVELS - 1; l++)
            cfg_pte[l] = mk_pte(rnd_ppn(), 1'b1, 1'b0, 1'b0);
        run_walk(36'h987654321, rnd_ppn(), 1'b1, 1'b1, "R10 upper rights");

        // random walks
        for (int n = 0; n < 60; n++) begin
            for (int l = 0; l < LEVELS; l++)
                cfg_pte[l] = mk_pte(rnd_ppn(), ($urandom % 16) != 0, $urandom % 2, $urandom % 2);
            run_walk({4'($urandom), 32'($urandom)}, rnd_ppn(), $urandom % 2, $urandom % 2, "random");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule